// File: doc/BRIEF.md
# Mean Common-Mode Calculator

This block estimates the common-mode shift of one event from an eight-channel front end. Each channel delivers one signed ADC sample, and the channels arrive one per clock in fixed channel order. A per-channel enable mask chooses which channels count. The block adds up the enabled samples and counts them. When the last channel of the event has been taken, it divides the sum by the count and rounds the quotient to the nearest integer.

Two results leave the block: the rounded mean and the number of channels that went into it. Each is a full byte with no parity bit, ready to be placed in a non-zero-suppressed event packet. A one-cycle done strobe marks a new result. The results then hold until the next event completes. Subtracting the common mode from the samples and building the packet are left to other logic.

Top module: `mcm_calc`

## Requirements
- R1: A sample is taken only in a cycle with `in_valid` high. The n-th sample taken within an event belongs to channel n, for n = 0 to 7, and the channel then wraps to 0. Cycles with `in_valid` low change nothing, whatever `in_sample` holds.
- R2: `done` is high for exactly one cycle. It goes high in the cycle after the channel-7 sample is taken and is low at all other times.
- R3: `count_out` is an unsigned 8-bit value equal to the number of channels of the event whose mask bit was 1 when their sample was taken. Bit i of `ch_mask` enables channel i, where 1 means enabled.
- R4: The sample of a masked channel has no effect on `mean_out`.
- R5: `mean_out` is the sum of the enabled samples divided by `count_out`, rounded to the nearest integer with halves rounded away from zero. It is an 8-bit two's-complement value using all eight bits, with no parity bit.
- R6: When no channel of an event is enabled, `mean_out` and `count_out` are both 0.
- R7: After reset, `done`, `mean_out` and `count_out` are 0. Between done pulses, `mean_out` and `count_out` keep their last values.
- R8: The full input range gives no overflow. Eight samples of -32 give a mean of -32, and eight samples of 31 give a mean of 31.
- R9: `in_sample` is read as a signed 6-bit two's-complement value, so bit 5 set means a negative sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | The current channel sample is present this cycle |
| in_sample | input | 6 | Signed ADC sample of the current channel |
| ch_mask | input | 8 | Per-channel enable, bit i for channel i |
| done | output | 1 | One-cycle pulse: new results are available |
| mean_out | output | 8 | Rounded mean common-mode shift, two's complement |
| count_out | output | 8 | Number of channels used in the mean |

## Verification
The bench aims at exact half-way sums such as 3/2 and -3/2. A design that truncates would report 1 or -1 instead of 2 or -2, and a design that rounds halves upward would report -1 for the negative case. It drives events that are all -32 and all 31, so an accumulator that is too narrow would wrap to the wrong sign, and it drives an event with an empty mask, where a divider left unguarded would report a garbage mean. Idle cycles carrying random sample data are inserted inside events, so a design that advances the channel on an idle cycle would shift the mask and report a wrong count and mean. Random masks with out-of-range values placed on masked channels would show any masked sample leaking into the sum.

// File: rtl/mcm_pkg.sv
// Package: mcm_pkg
// Holds the default geometry of the common-mode calculator.
// Assumes: the modules derive every internal width from these defaults.
package mcm_pkg;
    localparam int MCM_NUM_CH   = 8;
    localparam int MCM_SAMPLE_W = 6;
    localparam int MCM_OUT_W    = 8;
endpackage

// File: rtl/mcm_accum.sv
// Module: mcm_accum
// Takes channel samples one per valid cycle, keeps a running sum and a count
// of the enabled ones, and flags the cycle that carries the last channel.
// It offers the sum and count that include the current sample combinationally.
// Assumes: samples arrive in channel order 0..NUM_CH-1 and ch_mask is valid
// whenever in_valid is high.
module mcm_accum #(
    parameter int NUM_CH   = mcm_pkg::MCM_NUM_CH,
    parameter int SAMPLE_W = mcm_pkg::MCM_SAMPLE_W,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ACC_W   = SAMPLE_W + IDX_W,
    localparam int CNT_W   = $clog2(NUM_CH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [SAMPLE_W-1:0]     in_sample,
    input  logic [NUM_CH-1:0]       ch_mask,
    output logic                    frame_last,
    output logic signed [ACC_W-1:0] sum_next,
    output logic [CNT_W-1:0]        cnt_next
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

    logic [IDX_W-1:0]        idx_q;
    logic signed [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0]        cnt_q;
    logic                    take;
    logic signed [ACC_W-1:0] samp_ext;

    // Sign-extend the sample to the width of the accumulator.
    assign samp_ext = {{(ACC_W - SAMPLE_W){in_sample[SAMPLE_W-1]}}, in_sample};

    // Decide whether this cycle adds a sample and build the next totals.
    always_comb begin
        take       = in_valid && ch_mask[idx_q];
        frame_last = in_valid && (idx_q == LAST_IDX);
        sum_next   = acc_q + (take ? samp_ext : '0);
        cnt_next   = cnt_q + CNT_W'(take);
    end

    // Advance the channel index and the totals; clear them when an event closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            if (frame_last) begin
                idx_q <= '0;
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
                acc_q <= sum_next;
                cnt_q <= cnt_next;
            end
        end
    end
endmodule

// File: rtl/mcm_round_div.sv
// Module: mcm_round_div
// Combinational signed divide with halves rounded away from zero:
// mean = sign(sum) * floor((2|sum| + cnt) / (2 cnt)).
// The quotient comes from a fixed chain of SAMPLE_W shifted trial
// subtractions, which is enough because |mean| <= 2**(SAMPLE_W-1).
// Assumes: |sum| <= cnt * 2**(SAMPLE_W-1) and OUT_W >= SAMPLE_W.
// A count of zero gives a mean of zero.
module mcm_round_div #(
    parameter int NUM_CH   = mcm_pkg::MCM_NUM_CH,
    parameter int SAMPLE_W = mcm_pkg::MCM_SAMPLE_W,
    parameter int OUT_W    = mcm_pkg::MCM_OUT_W,
    localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ACC_W   = SAMPLE_W + IDX_W,
    localparam int CNT_W   = $clog2(NUM_CH + 1)
) (
    input  logic signed [ACC_W-1:0] sum,
    input  logic [CNT_W-1:0]        cnt,
    output logic [OUT_W-1:0]        mean
);
    localparam int NW = ACC_W + 1;
    localparam int QW = SAMPLE_W;
    localparam int WW = NW + QW;

    logic              neg;
    logic [NW-1:0]     sum_w;
    logic [NW-1:0]     mag;
    logic [WW-1:0]     num;
    logic [WW-1:0]     den;
    logic [QW:0][WW-1:0] rem;
    logic [QW-1:0]     quo;
    logic [OUT_W-1:0]  qx;

    // Take the magnitude, then form the rounding numerator and the doubled divisor.
    always_comb begin
        neg   = sum[ACC_W-1];
        sum_w = {sum[ACC_W-1], sum};
        mag   = neg ? (~sum_w + 1'b1) : sum_w;
        num   = (WW'(mag) << 1) + WW'(cnt);
        den   = WW'(cnt) << 1;
    end

    assign rem[QW] = num;

    // One trial subtraction per quotient bit, from the top bit down.
    for (genvar g = 0; g < QW; g++) begin : g_step
        logic [WW-1:0] shifted;
        assign shifted   = den << g;
        assign quo[g]    = (rem[g+1] >= shifted);
        assign rem[g]    = quo[g] ? (rem[g+1] - shifted) : rem[g+1];
    end

    // Restore the sign and force zero when no channel contributed.
    always_comb begin
        qx   = OUT_W'(quo);
        if (cnt == '0)
            mean = '0;
        else if (neg)
            mean = ~qx + 1'b1;
        else
            mean = qx;
    end
endmodule

// File: rtl/mcm_calc.sv
// Module: mcm_calc (top)
// Mean common-mode calculator for one event of NUM_CH channel samples.
// Samples arrive serially, one channel per valid cycle. One cycle after the
// last channel is taken, done pulses and the rounded mean and the channel
// count appear as full-width bytes. Both hold until the next event closes.
// Assumes: synchronous active-low reset; channel order 0..NUM_CH-1.
module mcm_calc #(
    parameter int NUM_CH   = mcm_pkg::MCM_NUM_CH,
    parameter int SAMPLE_W = mcm_pkg::MCM_SAMPLE_W,
    parameter int OUT_W    = mcm_pkg::MCM_OUT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [NUM_CH-1:0]   ch_mask,
    output logic                done,
    output logic [OUT_W-1:0]    mean_out,
    output logic [OUT_W-1:0]    count_out
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int ACC_W = SAMPLE_W + IDX_W;
    localparam int CNT_W = $clog2(NUM_CH + 1);

    logic                    frame_last;
    logic signed [ACC_W-1:0] sum_next;
    logic [CNT_W-1:0]        cnt_next;
    logic [OUT_W-1:0]        mean_c;

    mcm_accum #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .ch_mask    (ch_mask),
        .frame_last (frame_last),
        .sum_next   (sum_next),
        .cnt_next   (cnt_next)
    );

    mcm_round_div #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_div (
        .sum  (sum_next),
        .cnt  (cnt_next),
        .mean (mean_c)
    );

    // Capture the results on the last channel of an event and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            mean_out  <= '0;
            count_out <= '0;
        end else begin
            done <= frame_last;
            if (frame_last) begin
                mean_out  <= mean_c;
                count_out <= OUT_W'(cnt_next);
            end
        end
    end
endmodule

// File: rtl/mcm_calc_chk.sv
// Module: mcm_calc_chk
// Property checker for mcm_calc. It keeps its own channel position counter
// and checks done timing, the range of the results, and that they hold.
// Assumes: attached to every mcm_calc instance through the bind below.
module mcm_calc_chk #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 6,
    parameter int OUT_W    = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [NUM_CH-1:0]   ch_mask,
    input logic                done,
    input logic [OUT_W-1:0]    mean_out,
    input logic [OUT_W-1:0]    count_out
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);
    localparam int MAX_POS = (2 ** (SAMPLE_W - 1)) - 1;
    localparam int MIN_NEG = -(2 ** (SAMPLE_W - 1));

    logic [IDX_W-1:0] pos_q;
    logic             closing;

    // Track the position within the event independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (in_valid)
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end

    assign closing = in_valid && (pos_q == LAST);

    p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        closing |=> done);
    p_done_only_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !closing |=> !done);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(count_out) <= NUM_CH));
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && count_out == '0) |-> (mean_out == '0));
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'($signed(mean_out)) >= MIN_NEG && int'($signed(mean_out)) <= MAX_POS));
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mean_out) && $stable(count_out)));
endmodule

bind mcm_calc mcm_calc_chk #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .ch_mask   (ch_mask),
    .done      (done),
    .mean_out  (mean_out),
    .count_out (count_out)
);

// File: tb/mcm_calc_tb.sv
`timescale 1ns/1ps
// Bench for mcm_calc: directed corner events plus seeded random events,
// with random idle cycles inside events; results checked against bench models.
module mcm_calc_tb;
    localparam int N  = 8;
    localparam int SW = 6;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_sample = '0;
    logic [N-1:0]  ch_mask = '0;
    wire           done;
    wire  [OW-1:0] mean_out;
    wire  [OW-1:0] count_out;

    int checks = 0;
    int fails  = 0;
    int fs [N];
    logic [N-1:0] fm;

    always #2 clk = ~clk;

    mcm_calc u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .ch_mask(ch_mask), .done(done), .mean_out(mean_out), .count_out(count_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_cnt();
        int c = 0;
        for (int i = 0; i < N; i++) if (fm[i]) c++;
        return c;
    endfunction

    function automatic int model_mean();
        int s = 0, c = 0, a, q;
        for (int i = 0; i < N; i++) if (fm[i]) begin s += fs[i]; c++; end
        if (c == 0) return 0;
        a = (s < 0) ? -s : s;
        q = (2 * a + c) / (2 * c);
        return (s < 0) ? -q : q;
    endfunction

    function automatic int rnd_sample();
        return int'($urandom_range(63)) - 32;
    endfunction

    // Drive one event; gap_pct is the chance of an idle cycle before each channel.
    task automatic run_frame(input int gap_pct, input string tag);
        int em, ec;
        for (int ch = 0; ch < N; ch++) begin
            while (int'($urandom_range(99)) < gap_pct) begin
                @(negedge clk);
                in_valid  = 1'b0;
                in_sample = SW'($urandom);
                chk(done == 1'b0, "R2 no done inside event", int'(done), 0);
            end
            @(negedge clk);
            in_valid  = 1'b1;
            in_sample = SW'(fs[ch]);
            ch_mask   = fm;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_sample = SW'($urandom);
        em = model_mean();
        ec = model_cnt();
        chk(done == 1'b1, {"R2 done pulse ", tag}, int'(done), 1);
        chk(int'(count_out) == ec, {"R3 count ", tag}, int'(count_out), ec);
        chk(int'($signed(mean_out)) == em, {"R5 mean ", tag}, int'($signed(mean_out)), em);
    endtask

    // Idle for some cycles and confirm that done stays low and the results hold.
    task automatic hold_check(input int cycles);
        int m0, c0;
        m0 = int'($signed(mean_out));
        c0 = int'(count_out);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_sample = SW'($urandom);
            ch_mask   = N'($urandom);
        end
        chk(done == 1'b0, "R2 done single cycle", int'(done), 0);
        chk(int'($signed(mean_out)) == m0 && int'(count_out) == c0, "R7 hold mean",
            int'($signed(mean_out)), m0);
    endtask

    task automatic set_all(input int v);
        for (int i = 0; i < N; i++) fs[i] = v;
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd517);
        repeat (4) @(negedge clk);
        chk(done == 1'b0 && mean_out == '0 && count_out == '0, "R7 reset state",
            int'(mean_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mean_out == '0 && count_out == '0, "R7 after reset",
            int'(count_out), 0);

        // R5: positive half rounds up, with masked channels holding extremes (R4).
        set_all(31); fs[0] = 1; fs[1] = 2; fm = 8'b0000_0011;
        run_frame(0, "R5 +1.5 -> 2, R4 masked 31s");
        // R5, R9: negative half rounds away from zero.
        set_all(-32); fs[0] = -1; fs[1] = -2; fm = 8'b0000_0011;
        run_frame(0, "R5 R9 -1.5 -> -2");
        // R5: quarter fractions.
        set_all(0); fs[2] = 2; fs[3] = 1; fs[4] = 1; fs[5] = 1; fm = 8'b0011_1100;
        run_frame(0, "R5 1.25 -> 1");
        fs[2] = -2; fs[3] = -2; fs[4] = -2; fs[5] = -1;
        run_frame(0, "R5 R9 -1.75 -> -2");
        hold_check(5);
        // R8: extremes of the input range.
        set_all(-32); fm = 8'hFF;
        run_frame(0, "R8 all -32");
        set_all(31); fm = 8'hFF;
        run_frame(0, "R8 all 31");
        // R6: nothing enabled.
        for (int i = 0; i < N; i++) fs[i] = rnd_sample();
        fm = 8'h00;
        run_frame(0, "R6 empty mask");
        chk(mean_out == '0 && count_out == '0, "R6 empty gives zeros", int'(mean_out), 0);
        // R3 R4: only the last channel enabled.
        set_all(31); fs[7] = -32; fm = 8'h80;
        run_frame(0, "R3 R4 only ch7");
        // R1: many idle cycles with noise inside the event.
        for (int i = 0; i < N; i++) fs[i] = rnd_sample();
        fm = 8'b1010_0110;
        run_frame(60, "R1 idle cycles ignored");
        hold_check(3);

        // Random events.
        for (int f = 0; f < 80; f++) begin
            for (int i = 0; i < N; i++) fs[i] = rnd_sample();
            fm = N'($urandom);
            run_frame(20, "random R1 R3 R4 R5 R9");
            if (f % 10 == 0) hold_check(2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule